// File: doc/BRIEF.md
# Board System Control Register Slave

This block is a 32-bit register slave that covers a 4 KB address window. Software uses it to drive two board LEDs, to read a button status word, and to keep a free 32-bit scratch control word. It also reads two free-running timebase counters. One advances once per second and the other a hundred times per second. Both take their tick from a divider of the system clock. Software can load either counter with any value, and the counter then keeps counting up from that value.

Three offsets belong to a separate prescaled counter unit. The slave decodes these offsets, passes the access on over a select/write/index/data interface, and returns that unit's read data through its own registered read path. The internal logic of that unit lies outside this block.

The bus is one strobe per access. `bus_sel` together with `bus_wr` marks a write, which takes effect at that clock edge. `bus_sel` with `bus_wr` low marks a read, and its data appears on `bus_rdata` after that same edge.

Top module: `board_ctrl_regs`

## Requirements
- R1: While `rst` is high and after its release, `led_o`, `bus_rdata`, the LED word, the scratch word and both timebase counters are zero.
- R2: The LED word sits at byte offset 0x000. A write keeps only data bits [1:0]. Those bits drive `led_o` from the edge of the write onward, and a read returns them with bits [31:2] zero.
- R3: The button word sits at offset 0x008. It always reads as zero, and a write to it changes no register.
- R4: The scratch word sits at offset 0x04C. All 32 bits are stored, read back exactly as written, and drive nothing else.
- R5: The slow timebase sits at offset 0x010. Without writes, it counts the edges after reset release divided by CLK_HZ/SLOW_HZ, so it advances exactly once every CLK_HZ/SLOW_HZ cycles.
- R6: The fast timebase sits at offset 0x014 and advances once every CLK_HZ/FAST_HZ cycles.
- R7: A write to either timebase loads the written value. The counter then advances from that value at its normal rate, and the divider phase is not disturbed.
- R8: If a timebase write falls in the same cycle as that counter's tick, the written value is stored and that tick is lost.
- R9: Offsets 0x018, 0x01C and 0x020 go to the prescaled counter unit. During the strobe cycle, `psc_sel` is high, `psc_idx` is 0, 1 or 2 respectively, `psc_wr` follows `bus_wr`, and `psc_wdata` equals `bus_wdata`. A read returns the `psc_rdata` sampled in that cycle.
- R10: Any other offset is unmapped. This includes any address whose bits [1:0] are not zero. An unmapped read returns zero, an unmapped write changes nothing, and `psc_sel` stays low for it.
- R11: `bus_rdata` is registered. It changes only at the edge that accepts a read and holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| led_o | output | 2 | Board LED drives |
| psc_sel | output | 1 | Prescaled counter unit select |
| psc_wr | output | 1 | Write to prescaled counter unit |
| psc_idx | output | 2 | Register index in prescaled counter unit |
| psc_wdata | output | 32 | Write data to prescaled counter unit |
| psc_rdata | input | 32 | Read data from prescaled counter unit |

## Verification
The forwarding outputs are combinational, so the bench samples them in the strobe cycle itself, before the accepting edge. Write effects on `led_o` and read data on `bus_rdata` are due one edge later, and the bench samples them at the next falling edge. A read accepted at edge r reports a timebase value that includes ticks only up to edge r-1. The bench numbers edges from reset release and computes each expected count as the loaded value plus ticks after the load edge. The load-phase sweep places a write at every position of the fast divider period, including the position that coincides with a tick.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int LED_W  = 2;

    localparam logic [ADDR_W-1:0] OFS_LED     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_BTN     = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_TB_SLOW = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_TB_FAST = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_PCOUNT  = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_PLOAD   = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_PCUR    = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_MISC    = 12'h04C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_LED,
        SEL_BTN,
        SEL_TB_SLOW,
        SEL_TB_FAST,
        SEL_PCOUNT,
        SEL_PLOAD,
        SEL_PCUR,
        SEL_MISC
    } reg_sel_e;

    typedef enum logic [1:0] {
        PIDX_COUNT = 2'd0,
        PIDX_LOAD  = 2'd1,
        PIDX_CUR   = 2'd2,
        PIDX_NONE  = 2'd3
    } psc_idx_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_LED:     s = SEL_LED;
            OFS_BTN:     s = SEL_BTN;
            OFS_TB_SLOW: s = SEL_TB_SLOW;
            OFS_TB_FAST: s = SEL_TB_FAST;
            OFS_PCOUNT:  s = SEL_PCOUNT;
            OFS_PLOAD:   s = SEL_PLOAD;
            OFS_PCUR:    s = SEL_PCUR;
            OFS_MISC:    s = SEL_MISC;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic psc_idx_e psc_index(input reg_sel_e s);
        psc_idx_e p;
        case (s)
            SEL_PCOUNT: p = PIDX_COUNT;
            SEL_PLOAD:  p = PIDX_LOAD;
            SEL_PCUR:   p = PIDX_CUR;
            default:    p = PIDX_NONE;
        endcase
        return p;
    endfunction

    function automatic logic is_psc(input reg_sel_e s);
        return (s == SEL_PCOUNT) || (s == SEL_PLOAD) || (s == SEL_PCUR);
    endfunction

    function automatic int unsigned div_ratio(input int unsigned clk_hz,
                                              input int unsigned rate_hz);
        int unsigned r;
        r = (rate_hz == 0) ? 1 : clk_hz / rate_hz;
        return (r == 0) ? 1 : r;
    endfunction

endpackage

// File: rtl/board_ctrl_tick_div.sv
module board_ctrl_tick_div #(
    parameter int unsigned DIV = 10
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_count
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst)                cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick = (cnt_q == LAST);

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R5
        end else begin : g_every
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/board_ctrl_timebase.sv
module board_ctrl_timebase #(
    parameter int unsigned DIV = 10,
    parameter int          W   = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value
);
    logic tick;

    board_ctrl_tick_div #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (load) value <= load_val;
        else if (tick) value <= value + 1'b1;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> value == $past(load_val)); // R8
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> value == $past(value) + 1'b1); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(value)); // R5

endmodule

// File: rtl/board_ctrl_decode.sv
module board_ctrl_decode
    import board_ctrl_pkg::*;
(
    input  bus_req_t req,
    output reg_sel_e reg_sel,
    output logic     rd_stb,
    output logic     wr_stb,
    output logic     psc_hit,
    output psc_idx_e psc_idx
);
    always_comb begin
        reg_sel = decode_offset(req.addr);
        rd_stb  = req.sel && !req.wr;
        wr_stb  = req.sel &&  req.wr;
        psc_hit = req.sel && is_psc(reg_sel);
        psc_idx = psc_index(reg_sel);
    end
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import board_ctrl_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned SLOW_HZ = 1,
    parameter int unsigned FAST_HZ = 100,
    parameter int          TB_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [LED_W-1:0]  led_o,
    output logic              psc_sel,
    output logic              psc_wr,
    output logic [1:0]        psc_idx,
    output logic [DATA_W-1:0] psc_wdata,
    input  logic [DATA_W-1:0] psc_rdata
);
    localparam int NUM_TB = 2;

    bus_req_t          req;
    reg_sel_e          reg_sel;
    logic              rd_stb, wr_stb, psc_hit;
    psc_idx_e          pidx;
    logic [LED_W-1:0]  led_q;
    logic [DATA_W-1:0] misc_q;
    logic [DATA_W-1:0] rd_mux;
    logic [TB_W-1:0]   tb_val [NUM_TB];

    assign req = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    board_ctrl_decode u_dec (
        .req     (req),
        .reg_sel (reg_sel),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .psc_hit (psc_hit),
        .psc_idx (pidx)
    );

    // Timebase channels: 0 = slow, 1 = fast
    generate
        for (genvar ch = 0; ch < NUM_TB; ch++) begin : g_tb
            localparam int unsigned RATE = (ch == 0) ? SLOW_HZ : FAST_HZ;
            localparam int unsigned DIV  = div_ratio(CLK_HZ, RATE);
            localparam reg_sel_e    MINE = (ch == 0) ? SEL_TB_SLOW : SEL_TB_FAST;
            logic tb_load;
            logic [TB_W-1:0] tb_out;

            assign tb_load = wr_stb && (reg_sel == MINE);

            board_ctrl_timebase #(.DIV(DIV), .W(TB_W)) u_tb (
                .clk      (clk),
                .rst      (rst),
                .load     (tb_load),
                .load_val (bus_wdata[TB_W-1:0]),
                .value    (tb_out)
            );

            assign tb_val[ch] = tb_out;
        end
    endgenerate

    // Local storage registers
    always_ff @(posedge clk) begin
        if (rst) begin
            led_q  <= '0;
            misc_q <= '0;
        end else if (wr_stb) begin
            if (reg_sel == SEL_LED)  led_q  <= bus_wdata[LED_W-1:0];
            if (reg_sel == SEL_MISC) misc_q <= bus_wdata;
        end
    end

    assign led_o = led_q;

    // Read selection
    always_comb begin
        case (reg_sel)
            SEL_LED:     rd_mux = DATA_W'(led_q);
            SEL_BTN:     rd_mux = '0;
            SEL_TB_SLOW: rd_mux = DATA_W'(tb_val[0]);
            SEL_TB_FAST: rd_mux = DATA_W'(tb_val[1]);
            SEL_PCOUNT,
            SEL_PLOAD,
            SEL_PCUR:    rd_mux = psc_rdata;
            SEL_MISC:    rd_mux = misc_q;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (rd_stb) bus_rdata <= rd_mux;
    end

    // Forwarding to the prescaled counter unit
    assign psc_sel   = psc_hit;
    assign psc_wr    = psc_hit && bus_wr;
    assign psc_idx   = pidx;
    assign psc_wdata = bus_wdata;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R11
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && decode_offset(bus_addr) == SEL_NONE) |=> bus_rdata == '0); // R10
    AST_BTN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == OFS_BTN) |=> bus_rdata == '0); // R3
    AST_LED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == OFS_LED) |=> led_o == $past(bus_wdata[LED_W-1:0])); // R2
    AST_PSC_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        psc_sel |-> bus_sel); // R9

endmodule

// File: tb/board_ctrl_regs_bench.sv
`timescale 1ns/1ps
module board_ctrl_regs_bench;
    localparam int unsigned CLK_HZ = 1000;
    localparam int DIV_SLOW = 1000;
    localparam int DIV_FAST = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  led_o;
    logic        psc_sel, psc_wr;
    logic [1:0]  psc_idx;
    logic [31:0] psc_wdata, psc_rdata;

    int n_chk = 0, n_bad = 0;
    int edge_cnt = 0;

    logic [1:0]  led_m = '0;
    logic [31:0] misc_m = '0;
    logic [31:0] tb_base [2] = '{32'd0, 32'd0};
    int          tb_wedge [2] = '{0, 0};

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edge_cnt <= 0;
        else     edge_cnt <= edge_cnt + 1;
    end

    // Model of the prescaled counter unit read port
    assign psc_rdata = psc_sel ? (32'hC0DE_0000 | {30'b0, psc_idx}) : 32'hDEAD_BEEF;

    board_ctrl_regs #(.CLK_HZ(CLK_HZ), .SLOW_HZ(1), .FAST_HZ(100), .TB_W(32)) u_board_ctrl_regs (
        .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .led_o, .psc_sel, .psc_wr, .psc_idx, .psc_wdata, .psc_rdata
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic int div_of(input int ch);
        return (ch == 0) ? DIV_SLOW : DIV_FAST;
    endfunction

    function automatic logic [31:0] tb_exp(input int ch, input int k);
        return tb_base[ch] + 32'(k / div_of(ch) - tb_wedge[ch] / div_of(ch));
    endfunction

    function automatic int psc_of(input logic [11:0] a);
        case (a)
            12'h018: return 0;
            12'h01C: return 1;
            12'h020: return 2;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a, input int r);
        case (a)
            12'h000: return {30'b0, led_m};
            12'h008: return 32'h0;
            12'h010: return tb_exp(0, r - 1);
            12'h014: return tb_exp(1, r - 1);
            12'h018, 12'h01C, 12'h020: return 32'hC0DE_0000 | 32'(psc_of(a));
            12'h04C: return misc_m;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check_fwd(input logic [11:0] a, input logic wr, input logic [31:0] d);
        int p;
        p = psc_of(a);
        if (p < 0) begin
            chk("R10 psc_sel low", {31'b0, psc_sel}, 32'd0);
        end else begin
            chk("R9 psc_sel", {31'b0, psc_sel}, 32'd1);
            chk("R9 psc_idx", {30'b0, psc_idx}, 32'(p));
            chk("R9 psc_wr", {31'b0, psc_wr}, {31'b0, wr});
            if (wr) chk("R9 psc_wdata", psc_wdata, d);
        end
    endtask

    task automatic do_read(input logic [11:0] a, input string req);
        int r;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = 32'h5A5A_0F0F;
        #1;
        check_fwd(a, 1'b0, 32'h0);
        @(posedge clk); @(negedge clk);
        r = edge_cnt;
        bus_sel = 1'b0;
        chk(req, bus_rdata, exp_read(a, r));
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        check_fwd(a, 1'b1, d);
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        case (a)
            12'h000: led_m = d[1:0];
            12'h04C: misc_m = d;
            12'h010: begin tb_base[0] = d; tb_wedge[0] = edge_cnt; end
            12'h014: begin tb_base[1] = d; tb_wedge[1] = edge_cnt; end
            default: ;
        endcase
    endtask

    function automatic bit is_local(input logic [11:0] a);
        return a == 12'h000 || a == 12'h008 || a == 12'h010 || a == 12'h014 ||
               a == 12'h04C || psc_of(a) >= 0;
    endfunction

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        chk("R1 led_o in reset", {30'b0, led_o}, 32'd0);
        chk("R1 rdata in reset", bus_rdata, 32'd0);
        rst = 1'b0;
        do_read(12'h000, "R1 LED after reset");
        do_read(12'h04C, "R1 MISC after reset");
        do_read(12'h010, "R1 slow timebase after reset");
        do_read(12'h014, "R1 fast timebase after reset");
        chk("R1 led_o after reset", {30'b0, led_o}, 32'd0);

        // R2: LED mask sweep over low nibble with noise above
        for (int v = 0; v < 16; v++) begin
            do_write(12'h000, 32'hFFFF_FFF0 | 32'(v));
            chk("R2 led_o", {30'b0, led_o}, 32'(v & 3));
            do_read(12'h000, "R2 LED readback");
        end

        // R4: scratch patterns
        foreach (held[i]) begin
            do_write(12'h04C, 32'h1 << i);
            do_read(12'h04C, "R4 MISC walking one");
        end
        do_write(12'h04C, 32'hA5C3_3C5A);
        do_read(12'h04C, "R4 MISC pattern");

        // R3: button write ignored, reads zero
        do_write(12'h008, 32'hFFFF_FFFF);
        do_read(12'h008, "R3 BUTTON reads zero");
        do_read(12'h000, "R3 LED unchanged after BUTTON write");
        do_read(12'h04C, "R3 MISC unchanged after BUTTON write");

        // R11: registered read holds through idle and writes
        do_read(12'h04C, "R11 read MISC");
        held = bus_rdata;
        repeat (3) @(negedge clk);
        chk("R11 hold idle", bus_rdata, held);
        do_write(12'h000, 32'h1);
        chk("R11 hold across write", bus_rdata, held);

        // R5/R6: free counting observed over time
        for (int i = 0; i < 8; i++) begin
            repeat (7) @(negedge clk);
            do_read(12'h014, "R6 fast timebase count");
        end

        // R7/R8: load at every phase of the fast divider period
        for (int p = 0; p < DIV_FAST; p++) begin
            while (((edge_cnt + 1) % DIV_FAST) != p) @(negedge clk);
            do_write(12'h014, 32'd1000 * 32'(p) + 32'd7);
            do_read(12'h014, (p == 0) ? "R8 load on tick keeps written value" : "R7 load value");
            repeat (25) @(negedge clk);
            do_read(12'h014, "R7 counts on from load");
        end

        // R9: forwarded writes and reads
        do_write(12'h018, 32'h1111_2222);
        do_write(12'h01C, 32'h3333_4444);
        do_write(12'h020, 32'h5555_6666);
        do_read(12'h018, "R9 forwarded read 0x018");
        do_read(12'h01C, "R9 forwarded read 0x01C");
        do_read(12'h020, "R9 forwarded read 0x020");

        // R10: writes to every unmapped word leave registers unchanged
        for (int w = 0; w < 1024; w++) begin
            if (!is_local(12'(w * 4))) do_write(12'(w * 4), 32'hFFFF_FFFF ^ 32'(w));
        end
        do_write(12'h001, 32'hFFFF_FFFF);
        do_write(12'h04E, 32'h0);
        do_read(12'h000, "R10 LED unchanged");
        do_read(12'h04C, "R10 MISC unchanged");
        do_read(12'h014, "R10 fast timebase unchanged");

        // R10/R2..R9: read sweep over every word offset plus misaligned ones
        for (int w = 0; w < 1024; w++) begin
            do_read(12'(w * 4), is_local(12'(w * 4)) ? "R10 sweep mapped" : "R10 sweep unmapped zero");
        end
        do_read(12'h002, "R10 misaligned read zero");
        do_read(12'h04D, "R10 misaligned read zero");

        // R5/R7: slow timebase with load near the top of range
        do_write(12'h010, 32'hFFFF_FFFE);
        for (int i = 0; i < 12; i++) begin
            repeat (190) @(negedge clk);
            do_read(12'h010, "R5 slow timebase count");
        end
        do_read(12'h014, "R6 fast timebase long run");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule